// File: doc/BRIEF.md
# Posted-Write Bridge with Read Ordering

This block joins an upstream initiator port to a downstream target port and forwards requests in one direction. Memory-space writes are accepted into a small posting queue and acknowledged to the initiator right away. The queue then drains to the target whenever the target accepts requests. Posting lets the initiator go on without waiting for each write to land.

The cost of posting is that a read could overtake writes that are still queued and return stale data. The bridge prevents this. Every read, whatever initiator tag it carries, is held until the queue is empty, and only then goes to the target. I/O-space writes are never posted. They also wait for the queue to empty, then go downstream, and the initiator is acknowledged only after the target reports completion.

Both ports use a valid/ready request channel that carries address, space flag, write flag, write data and, upstream, an initiator tag. Each port also has a response channel. Two status outputs expose the queue occupancy and whether a non-posted request is waiting for the drain.

Top module: `pwb_bridge`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `up_req_ready` is 1, `up_rsp_valid` is 0, `dn_req_valid` is 0, `pend_count` is 0 and `busy` is 0.
- R2: A memory-space write (`up_req_write`=1, `up_req_io`=0) accepted at a clock edge raises `up_rsp_valid` with `up_rsp_write`=1, its tag and `up_rsp_rdata`=0 for exactly the following cycle, whether or not the target has taken it.
- R3: With DEPTH (4) writes pending, `up_req_ready` is 0 for a memory-space write, and no entry is lost or overwritten.
- R4: Posted writes reach the target in the order they were accepted, one per downstream handshake, with `dn_req_io`=0 and `dn_req_write`=1. A request held with `dn_req_ready` low keeps its fields stable.
- R5: A read (`up_req_write`=0) is presented downstream only when `pend_count` is 0. Its response carries the target data, so it reflects every write accepted before the read.
- R6: The drain-before-read rule does not depend on `up_req_id`. A read with one tag sees the writes of other tags, and the response carries the tag of the read.
- R7: An I/O-space write (`up_req_io`=1, `up_req_write`=1) is not acknowledged upstream until the target has raised `dn_rsp_valid` for it. The acknowledge follows one cycle later.
- R8: An I/O-space write is presented downstream only when `pend_count` is 0, so downstream order matches arrival order.
- R9: `pend_count` equals the number of accepted, not yet drained posted writes. `busy` is 1 while a non-posted request waits for the drain, and no new request is accepted while it is 1.
- R10: A reset pulse empties the queue and drops a waiting read. No response and no downstream request follows for the dropped work.
- R11: Only one non-posted request is outstanding at a time. The upstream port accepts nothing from its acceptance until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted when high with valid |
| up_req_addr | input | AW (16) | Request address |
| up_req_io | input | 1 | 1 = I/O space, 0 = memory space |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_wdata | input | DW (32) | Write data |
| up_req_id | input | IW (2) | Initiator tag |
| up_rsp_valid | output | 1 | Upstream response, one-cycle pulse |
| up_rsp_write | output | 1 | Response belongs to a write |
| up_rsp_id | output | IW (2) | Tag of the answered request |
| up_rsp_rdata | output | DW (32) | Read data (0 for writes) |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Target accepts the request |
| dn_req_addr | output | AW (16) | Downstream address |
| dn_req_io | output | 1 | Downstream space flag |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_wdata | output | DW (32) | Downstream write data |
| dn_rsp_valid | input | 1 | Target completion for a read or I/O write |
| dn_rsp_rdata | input | DW (32) | Target read data |
| pend_count | output | CW (3) | Posted writes not yet drained |
| busy | output | 1 | A non-posted request waits for the drain |

## Verification
The first pattern is a stalled target with writes piling up. It separates immediate acknowledgement from completion and shows the stall when the queue is full. The second pattern is a write followed by a read of the same address under both the same tag and a different tag. A bridge that lets the read overtake returns the older value here, which a correctly ordered one never does. The third pattern places I/O writes behind posted writes; it tells a true non-posted path, acknowledged only after the target completes, from one that acknowledges early or jumps the queue. A long mixed run with a target that stalls at random, and a reset in the middle of a wait, cover ordering under timing jitter and the discarding of abandoned work.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    ST_OPEN  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } ord_state_e;

  // wrap a ring pointer
  function automatic int unsigned ptr_next(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction

  // occupancy after one cycle of pushes and pops
  function automatic int unsigned occ_next(input int unsigned occ, input logic push, input logic pop);
    int unsigned r;
    r = occ;
    if (push && !pop) r = occ + 1;
    if (pop && !push) r = occ - 1;
    return r;
  endfunction

  // a request travels through the posting queue only when it is a memory write
  function automatic logic is_posted(input logic write, input logic io);
    return write && !io;
  endfunction

endpackage

// File: rtl/pwb_post_fifo.sv
module pwb_post_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  import pwb_pkg::*;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PW'(i)) begin
        addr_q[i] <= push_addr;
        data_q[i] <= push_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ptr_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(ptr_next(int'(rd_ptr), DEPTH));
      count_q <= CW'(occ_next(int'(count_q), push, pop));
    end
  end

  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];
  assign empty     = (count_q == '0);
  assign full      = (count_q == CW'(DEPTH));
  assign count     = count_q;

endmodule

// File: rtl/pwb_order_ctrl.sv
module pwb_order_ctrl #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_req_valid,
  input  logic [AW-1:0] up_req_addr,
  input  logic          up_req_io,
  input  logic          up_req_write,
  input  logic [DW-1:0] up_req_wdata,
  input  logic [IW-1:0] up_req_id,
  input  logic          fifo_full,
  input  logic          fifo_empty,
  input  logic          held_hs,
  input  logic          dn_rsp_valid,
  output logic          up_req_ready,
  output logic          push,
  output logic          np_accept,
  output logic          np_done,
  output logic          held_sel,
  output logic          waiting,
  output logic [AW-1:0] held_addr,
  output logic          held_io,
  output logic          held_write,
  output logic [DW-1:0] held_wdata,
  output logic [IW-1:0] held_id
);
  import pwb_pkg::*;

  ord_state_e state_q, state_d;
  logic       req_posted;
  logic       accept;

  assign req_posted   = is_posted(up_req_write, up_req_io);
  assign up_req_ready = (state_q == ST_OPEN) && !(req_posted && fifo_full);
  assign accept       = up_req_valid && up_req_ready;
  assign push         = accept && req_posted;
  assign np_accept    = accept && !req_posted;
  assign held_sel     = (state_q == ST_ISSUE);
  assign waiting      = (state_q == ST_DRAIN);
  assign np_done      = (state_q == ST_WAIT) && dn_rsp_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPEN:  if (np_accept)  state_d = ST_DRAIN;
      ST_DRAIN: if (fifo_empty) state_d = ST_ISSUE;
      ST_ISSUE: if (held_hs)    state_d = ST_WAIT;
      ST_WAIT:  if (dn_rsp_valid) state_d = ST_OPEN;
      default:  state_d = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OPEN;
    else     state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_addr  <= '0;
      held_io    <= 1'b0;
      held_write <= 1'b0;
      held_wdata <= '0;
      held_id    <= '0;
    end else if (np_accept) begin
      held_addr  <= up_req_addr;
      held_io    <= up_req_io;
      held_write <= up_req_write;
      held_wdata <= up_req_wdata;
      held_id    <= up_req_id;
    end
  end

endmodule

// File: rtl/pwb_dn_mux.sv
module pwb_dn_mux #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          held_sel,
  input  logic [AW-1:0] held_addr,
  input  logic          held_io,
  input  logic          held_write,
  input  logic [DW-1:0] held_wdata,
  input  logic          fifo_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          dn_req_ready,
  output logic          dn_req_valid,
  output logic [AW-1:0] dn_req_addr,
  output logic          dn_req_io,
  output logic          dn_req_write,
  output logic [DW-1:0] dn_req_wdata,
  output logic          pop,
  output logic          held_hs
);
  logic fifo_sel;

  assign fifo_sel = !held_sel && !fifo_empty;

  always_comb begin
    if (held_sel) begin
      dn_req_valid = 1'b1;
      dn_req_addr  = held_addr;
      dn_req_io    = held_io;
      dn_req_write = held_write;
      dn_req_wdata = held_wdata;
    end else begin
      dn_req_valid = fifo_sel;
      dn_req_addr  = head_addr;
      dn_req_io    = 1'b0;
      dn_req_write = 1'b1;
      dn_req_wdata = head_data;
    end
  end

  assign pop     = fifo_sel && dn_req_ready;
  assign held_hs = held_sel && dn_req_ready;

endmodule

// File: rtl/pwb_rsp_gen.sv
module pwb_rsp_gen #(
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [IW-1:0] up_req_id,
  input  logic          np_done,
  input  logic          held_write,
  input  logic [IW-1:0] held_id,
  input  logic [DW-1:0] dn_rsp_rdata,
  output logic          up_rsp_valid,
  output logic          up_rsp_write,
  output logic [IW-1:0] up_rsp_id,
  output logic [DW-1:0] up_rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      up_rsp_valid <= 1'b0;
      up_rsp_write <= 1'b0;
      up_rsp_id    <= '0;
      up_rsp_rdata <= '0;
    end else if (np_done) begin
      up_rsp_valid <= 1'b1;
      up_rsp_write <= held_write;
      up_rsp_id    <= held_id;
      up_rsp_rdata <= held_write ? '0 : dn_rsp_rdata;
    end else if (push) begin
      up_rsp_valid <= 1'b1;
      up_rsp_write <= 1'b1;
      up_rsp_id    <= up_req_id;
      up_rsp_rdata <= '0;
    end else begin
      up_rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pwb_bridge.sv
module pwb_bridge #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int IW    = 2,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_req_valid,
  output logic          up_req_ready,
  input  logic [AW-1:0] up_req_addr,
  input  logic          up_req_io,
  input  logic          up_req_write,
  input  logic [DW-1:0] up_req_wdata,
  input  logic [IW-1:0] up_req_id,
  output logic          up_rsp_valid,
  output logic          up_rsp_write,
  output logic [IW-1:0] up_rsp_id,
  output logic [DW-1:0] up_rsp_rdata,
  output logic          dn_req_valid,
  input  logic          dn_req_ready,
  output logic [AW-1:0] dn_req_addr,
  output logic          dn_req_io,
  output logic          dn_req_write,
  output logic [DW-1:0] dn_req_wdata,
  input  logic          dn_rsp_valid,
  input  logic [DW-1:0] dn_rsp_rdata,
  output logic [CW-1:0] pend_count,
  output logic          busy
);
  // named internal events
  logic          ev_push, ev_pop, ev_np_accept, ev_np_done;
  logic          held_hs, held_sel;
  logic          fifo_empty, fifo_full;
  logic [AW-1:0] head_addr, held_addr;
  logic [DW-1:0] head_data, held_wdata;
  logic          held_io, held_write;
  logic [IW-1:0] held_id;

  pwb_post_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst),
    .push(ev_push), .push_addr(up_req_addr), .push_data(up_req_wdata),
    .pop(ev_pop), .head_addr(head_addr), .head_data(head_data),
    .empty(fifo_empty), .full(fifo_full), .count(pend_count)
  );

  pwb_order_ctrl #(.AW(AW), .DW(DW), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst),
    .up_req_valid(up_req_valid), .up_req_addr(up_req_addr), .up_req_io(up_req_io),
    .up_req_write(up_req_write), .up_req_wdata(up_req_wdata), .up_req_id(up_req_id),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .held_hs(held_hs),
    .dn_rsp_valid(dn_rsp_valid), .up_req_ready(up_req_ready), .push(ev_push),
    .np_accept(ev_np_accept), .np_done(ev_np_done), .held_sel(held_sel), .waiting(busy),
    .held_addr(held_addr), .held_io(held_io), .held_write(held_write),
    .held_wdata(held_wdata), .held_id(held_id)
  );

  pwb_dn_mux #(.AW(AW), .DW(DW)) u_mux (
    .held_sel(held_sel), .held_addr(held_addr), .held_io(held_io),
    .held_write(held_write), .held_wdata(held_wdata),
    .fifo_empty(fifo_empty), .head_addr(head_addr), .head_data(head_data),
    .dn_req_ready(dn_req_ready), .dn_req_valid(dn_req_valid), .dn_req_addr(dn_req_addr),
    .dn_req_io(dn_req_io), .dn_req_write(dn_req_write), .dn_req_wdata(dn_req_wdata),
    .pop(ev_pop), .held_hs(held_hs)
  );

  pwb_rsp_gen #(.DW(DW), .IW(IW)) u_rsp (
    .clk(clk), .rst(rst), .push(ev_push), .up_req_id(up_req_id),
    .np_done(ev_np_done), .held_write(held_write), .held_id(held_id),
    .dn_rsp_rdata(dn_rsp_rdata), .up_rsp_valid(up_rsp_valid), .up_rsp_write(up_rsp_write),
    .up_rsp_id(up_rsp_id), .up_rsp_rdata(up_rsp_rdata)
  );

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          up_req_valid,
  input logic          up_req_ready,
  input logic          up_req_io,
  input logic          up_req_write,
  input logic          up_rsp_valid,
  input logic          up_rsp_write,
  input logic          dn_req_valid,
  input logic          dn_req_ready,
  input logic [AW-1:0] dn_req_addr,
  input logic          dn_req_io,
  input logic          dn_req_write,
  input logic [CW-1:0] pend_count,
  input logic          busy,
  input logic          ev_push,
  input logic          ev_pop,
  input logic          ev_np_accept,
  input logic          ev_np_done
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (pend_count == CW'(DEPTH)) |-> !ev_push);

  p_posted_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (up_req_valid && up_req_ready && up_req_write && !up_req_io) |=> (up_rsp_valid && up_rsp_write));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_write)));

  p_read_drained_r5: assert property (@(posedge clk) disable iff (rst)
    (dn_req_valid && !dn_req_write) |-> (pend_count == '0));

  p_io_no_early_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (up_req_valid && up_req_ready && up_req_io && up_req_write) |=> !up_rsp_valid);

  p_io_drained_r8: assert property (@(posedge clk) disable iff (rst)
    (dn_req_valid && dn_req_io) |-> (pend_count == '0));

  p_count_track_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pend_count == $past(pend_count) + {{(CW-1){1'b0}}, $past(ev_push)}
                                               - {{(CW-1){1'b0}}, $past(ev_pop)}));

  p_busy_stall_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !up_req_ready);

  p_reset_clean_r10: assert property (@(posedge clk)
    rst |=> (pend_count == '0 && !busy && !up_rsp_valid));

  p_single_np_r11: assert property (@(posedge clk) disable iff (rst)
    ev_np_accept |=> !up_req_ready);

  p_np_closes_r11: assert property (@(posedge clk) disable iff (rst)
    ev_np_done |=> up_rsp_valid);
endmodule

bind pwb_bridge pwb_checker #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (.*);

// File: tb/sim_pwb_bridge.sv
`timescale 1ns/1ps
module sim_pwb_bridge;
  localparam int AW = 16, DW = 32, IW = 2, DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          up_req_valid = 0, up_req_io = 0, up_req_write = 0;
  logic [AW-1:0] up_req_addr = '0;
  logic [DW-1:0] up_req_wdata = '0;
  logic [IW-1:0] up_req_id = '0;
  logic          up_req_ready, up_rsp_valid, up_rsp_write;
  logic [IW-1:0] up_rsp_id;
  logic [DW-1:0] up_rsp_rdata;
  logic          dn_req_valid, dn_req_io, dn_req_write;
  logic [AW-1:0] dn_req_addr;
  logic [DW-1:0] dn_req_wdata;
  logic          dn_req_ready = 0, dn_rsp_valid = 0;
  logic [DW-1:0] dn_rsp_rdata = '0;
  logic [CW-1:0] pend_count;
  logic          busy;

  pwb_bridge #(.AW(AW), .DW(DW), .IW(IW), .DEPTH(DEPTH)) u0 (.*);

  int n_checks = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- target model ----------------
  logic          tgt_hold = 1'b1, tgt_jitter = 1'b0;
  logic [DW-1:0] tmem [16];
  logic [DW-1:0] tio  [16];
  logic [DW-1:0] sh_mem [16];
  logic [DW-1:0] sh_io  [16];
  int            rsp_wait = 0;
  logic [DW-1:0] rsp_data = '0;

  initial begin
    for (int i = 0; i < 16; i++) begin
      tmem[i] = '0; tio[i] = '0; sh_mem[i] = '0; sh_io[i] = '0;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      dn_req_ready <= 1'b0;
      dn_rsp_valid <= 1'b0;
      rsp_wait     <= 0;
    end else begin
      dn_req_ready <= !tgt_hold && !(tgt_jitter && ($urandom % 3 == 0));
      dn_rsp_valid <= (rsp_wait == 1);
      dn_rsp_rdata <= (rsp_wait == 1) ? rsp_data : 32'hDEAD_BEEF;
      if (rsp_wait > 0) rsp_wait <= rsp_wait - 1;
      if (dn_req_valid && dn_req_ready) begin
        if (dn_req_write && !dn_req_io) tmem[dn_req_addr[3:0]] <= dn_req_wdata;
        else begin
          if (dn_req_write) tio[dn_req_addr[3:0]] <= dn_req_wdata;
          rsp_data <= dn_req_io ? tio[dn_req_addr[3:0]] : tmem[dn_req_addr[3:0]];
          rsp_wait <= 2;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [49:0] exp_dn [$];   // {addr, io, write, wdata}
  logic [35:0] exp_up [$];   // {np, write, id, rdata}
  bit dn_seen = 0;
  int up_rsp_cnt = 0, dn_hs_cnt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (dn_req_valid && dn_req_ready) begin
        logic [49:0] got, e;
        dn_hs_cnt++;
        got = {dn_req_addr, dn_req_io, dn_req_write, dn_req_wdata};
        if (exp_dn.size() == 0) check(0, "R4 unexpected downstream request", got, 0);
        else begin
          e = exp_dn.pop_front();
          check(got == e, "R4/R5/R8 downstream order", got, e);
        end
      end
      if (dn_rsp_valid) dn_seen = 1;
      if (up_rsp_valid) begin
        logic [35:0] u;
        logic [34:0] g;
        up_rsp_cnt++;
        g = {up_rsp_write, up_rsp_id, up_rsp_rdata};
        if (exp_up.size() == 0) check(0, "R10 unexpected upstream response", g, 0);
        else begin
          u = exp_up.pop_front();
          check(g == u[34:0], "R5/R6 upstream response", g, u[34:0]);
          if (u[35]) begin
            check(dn_seen, "R7 non-posted ack after target completion", dn_seen, 1);
            dn_seen = 0;
          end
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input logic [IW-1:0] id, input bit io, input bit wr,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] wd;
    bit posted;
    wd = wr ? d : '0;
    posted = wr && !io;
    exp_dn.push_back({a, io, wr, wd});
    if (wr) exp_up.push_back({!posted, 1'b1, id, 32'h0});
    else    exp_up.push_back({1'b1, 1'b0, id, io ? sh_io[a[3:0]] : sh_mem[a[3:0]]});
    if (wr) begin
      if (io) sh_io[a[3:0]] = d;
      else    sh_mem[a[3:0]] = d;
    end
    @(negedge clk);
    up_req_valid = 1; up_req_id = id; up_req_io = io; up_req_write = wr;
    up_req_addr = a; up_req_wdata = wd;
    #1;
    while (!up_req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    up_req_valid = 0;
    if (posted) check(up_rsp_valid && up_rsp_write && up_rsp_id == id, "R2 posted write acknowledged",
                      {up_rsp_valid, up_rsp_write}, 2'b11);
  endtask

  task automatic wait_quiet();
    while (exp_dn.size() != 0 || exp_up.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int c0, h0;
    repeat (3) @(negedge clk);
    #1;
    check(up_req_ready && !up_rsp_valid && !dn_req_valid && pend_count == 0 && !busy,
          "R1 reset state", {up_req_ready, up_rsp_valid, dn_req_valid, pend_count, busy}, 7'b1000000);
    @(negedge clk); rst = 0;
    @(negedge clk); #1;
    check(up_req_ready && !dn_req_valid && pend_count == 0 && !busy, "R1 after reset",
          {up_req_ready, dn_req_valid, busy}, 3'b100);

    // R2 / R3: stalled target, queue fills
    tgt_hold = 1;
    issue(0, 0, 1, 16'h0001, 32'hA000_0001);
    issue(1, 0, 1, 16'h0002, 32'hA000_0002);
    check(pend_count == 2, "R9 count with stalled target", pend_count, 2);
    issue(2, 0, 1, 16'h0003, 32'hA000_0003);
    issue(3, 0, 1, 16'h0004, 32'hA000_0004);
    check(pend_count == 4, "R3 queue full", pend_count, 4);
    @(negedge clk);
    up_req_valid = 1; up_req_write = 1; up_req_io = 0; up_req_addr = 16'h0005;
    #1;
    check(!up_req_ready, "R3 backpressure when full", up_req_ready, 0);
    @(negedge clk); #1;
    check(!up_req_ready && pend_count == 4, "R3 still stalled", {up_req_ready, pend_count}, 4);
    up_req_valid = 0;
    tgt_hold = 0;
    wait_quiet();
    check(pend_count == 0, "R9 drained count", pend_count, 0);

    // R5: read waits for drain, same tag
    tgt_hold = 1;
    issue(1, 0, 1, 16'h0003, 32'h1111_0003);
    issue(1, 0, 0, 16'h0003, 32'h0);
    #1;
    check(busy, "R9 busy while read waits", busy, 1);
    check(dn_req_valid && dn_req_write, "R5 head is the write, not the read",
          {dn_req_valid, dn_req_write}, 2'b11);
    check(!up_req_ready, "R11 no accept while non-posted outstanding", up_req_ready, 0);
    repeat (5) @(negedge clk);
    check(busy && pend_count == 1, "R5 read still held", {busy, pend_count}, {1'b1, 3'd1});
    tgt_hold = 0;
    wait_quiet();

    // R6: writes by other tags, read by another tag
    tgt_hold = 1;
    issue(2, 0, 1, 16'h0005, 32'h2222_0005);
    issue(3, 0, 1, 16'h0005, 32'h3333_0005);
    issue(0, 0, 0, 16'h0005, 32'h0);
    tgt_hold = 0;
    wait_quiet();

    // R7 / R8: I/O write behind posted writes
    tgt_hold = 1;
    issue(0, 0, 1, 16'h0008, 32'h4444_0008);
    issue(0, 0, 1, 16'h0009, 32'h4444_0009);
    issue(1, 1, 1, 16'h0002, 32'h5555_0002);
    #1;
    check(busy, "R8 I/O write waits for drain", busy, 1);
    tgt_hold = 0;
    wait_quiet();
    issue(2, 1, 0, 16'h0002, 32'h0);
    wait_quiet();
    tgt_hold = 1;
    c0 = up_rsp_cnt;
    issue(3, 1, 1, 16'h0006, 32'h6666_0006);
    repeat (6) @(negedge clk);
    check(up_rsp_cnt == c0, "R7 no I/O ack before target completes", up_rsp_cnt, c0);
    tgt_hold = 0;
    wait_quiet();

    // R10: reset drops a waiting read
    tgt_hold = 1;
    issue(0, 0, 1, 16'h0007, 32'h7777_0007);
    issue(1, 0, 0, 16'h0007, 32'h0);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    exp_dn.delete(); exp_up.delete(); dn_seen = 0;
    for (int i = 0; i < 16; i++) begin sh_mem[i] = tmem[i]; sh_io[i] = tio[i]; end
    rst = 0;
    #1;
    check(pend_count == 0 && !busy && up_req_ready, "R10 reset empties queue",
          {pend_count, busy, up_req_ready}, 5'b00001);
    c0 = up_rsp_cnt; h0 = dn_hs_cnt;
    tgt_hold = 0;
    repeat (10) @(negedge clk);
    check(up_rsp_cnt == c0 && dn_hs_cnt == h0, "R10 dropped work stays dropped",
          {up_rsp_cnt, dn_hs_cnt}, {c0, h0});

    // mixed traffic with a jittering target
    tgt_jitter = 1;
    for (int k = 0; k < 300; k++) begin
      int sel;
      sel = $urandom % 8;
      issue(IW'($urandom), sel == 7, sel < 5 || sel == 7, AW'($urandom % 16), $urandom);
    end
    wait_quiet();
    check(exp_dn.size() == 0 && exp_up.size() == 0, "R4 all expected items seen",
          exp_dn.size() + exp_up.size(), 0);

    summary();
    $finish;
  end
endmodule